// File: doc/BRIEF.md
# Signed-Digit Recoder for Constant Multipliers

The block takes an unsigned binary word and rewrites it as a string of signed digits. Each digit is weighted by a power of two. A shift-and-add constant multiplier can then use one adder or subtractor per nonzero digit. The default mode gives the canonical signed-digit form, with digits in {-1, 0, +1}. It forms three times the input with a single wide addition. Each digit is then the difference between one bit of that sum and the input bit at the same position. No two adjacent digits are both nonzero. A second mode gives radix-4 Booth digits in {-2, -1, 0, +1, +2}. Each Booth digit sits at an even bit position.

A request is one `in_valid` cycle, carrying a value and a mode. The result is registered and appears one cycle later, together with a count of its nonzero digits. Requests may arrive back to back, and the mode may change on every request. When no request is present the outputs hold their last result.

Top module: `csd_recoder`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. Reset drives `out_valid`, every digit flag and `out_count` to zero.
- R2: In signed-digit mode (`in_mode` = 0), the sum of the digits equals the input value. A digit at position i counts as +2^i when its nonzero flag is set and its negative flag is clear, and as -2^i when both flags are set.
- R3: In signed-digit mode, no two adjacent positions both carry a nonzero digit.
- R4: `out_count` equals the number of set bits in `out_nz`. In signed-digit mode it never exceeds (W+2)/2.
- R5: Digit encoding: bit i of `out_nz` marks a nonzero digit, bit i of `out_neg` marks a negative sign and bit i of `out_dbl` marks magnitude 2. The sign and magnitude-2 flags are only set when the nonzero flag is set. Signed-digit mode never sets `out_dbl`.
- R6: In Booth mode (`in_mode` = 1), Booth digit j sits at position 2j. Its value is -2·b(2j+1) + b(2j) + b(2j-1), where b(-1) = 0 and input bits at or above W read as 0. Odd positions are always zero.
- R7: For W = 8, the input 61 gives, in signed-digit mode, +1 at position 6, -1 at position 2, +1 at position 0 and zero elsewhere.
- R8: Each result uses the mode captured with its own request, including when back-to-back requests alternate modes.
- R9: In a cycle with `in_valid` low, every output except `out_valid` keeps its previous value, whatever `in_value` and `in_mode` carry.
- R10: The all-ones input recodes in signed-digit mode to +1 at position W and -1 at position 0, with a count of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 = signed-digit, 1 = radix-4 Booth |
| in_value | input | W | Unsigned value to recode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_mode | output | 1 | Mode of the presented result |
| out_nz | output | W+1 | Per-position nonzero flag |
| out_neg | output | W+1 | Per-position negative flag |
| out_dbl | output | W+1 | Per-position magnitude-2 flag |
| out_count | output | CW | Number of nonzero digits, CW = clog2(W+2) |

## Verification
A result from one mode can leave the output register in the same cycle that a request in the other mode is captured. The bench provokes this by issuing back-to-back requests with alternating modes, both as directed pairs and as a long random stream. Each presented result is compared field by field against a reference computed for its own request. A serial digit-by-digit scan gives the signed-digit reference, and direct evaluation of the bit groups gives the Booth reference. A result that has picked up the neighbouring request's mode or value therefore shows up as a mismatch on some position.

// File: rtl/csd_recoder_pkg.sv
package csd_recoder_pkg;

  typedef enum logic {
    MODE_CSD   = 1'b0,
    MODE_BOOTH = 1'b1
  } rec_mode_e;

  typedef struct packed {
    logic nz;
    logic neg;
    logic dbl;
  } sdigit_t;

  // Radix-4 group {b(2j+1), b(2j), b(2j-1)} -> signed digit.
  function automatic sdigit_t booth_group(input logic [2:0] g);
    sdigit_t d;
    unique case (g)
      3'b000, 3'b111: d = '{nz: 1'b0, neg: 1'b0, dbl: 1'b0};
      3'b001, 3'b010: d = '{nz: 1'b1, neg: 1'b0, dbl: 1'b0};
      3'b011:         d = '{nz: 1'b1, neg: 1'b0, dbl: 1'b1};
      3'b100:         d = '{nz: 1'b1, neg: 1'b1, dbl: 1'b1};
      default:        d = '{nz: 1'b1, neg: 1'b1, dbl: 1'b0};
    endcase
    return d;
  endfunction

  // Digit from one bit of 3B and the input bit one place higher: h - b.
  function automatic sdigit_t csd_digit(input logic h, input logic b);
    sdigit_t d;
    d.nz  = h ^ b;
    d.neg = b & ~h;
    d.dbl = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/csd_core.sv
module csd_core
  import csd_recoder_pkg::*;
#(
  parameter int W = 8,
  localparam int ND = W + 1
) (
  input  logic [W-1:0]  value,
  output logic [ND-1:0] nz,
  output logic [ND-1:0] neg,
  output logic          top_carry
);
  localparam int HW = W + 2;

  logic [HW-1:0] b_ext;
  logic [HW-1:0] triple;

  assign b_ext  = {2'b00, value};
  assign triple = b_ext + {b_ext[HW-2:0], 1'b0};

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_dig
      sdigit_t d;
      assign d      = csd_digit(triple[i+1], b_ext[i+1]);
      assign nz[i]  = d.nz;
      assign neg[i] = d.neg;
    end
  endgenerate

  assign top_carry = nz[ND-1];
endmodule

// File: rtl/booth_core.sv
module booth_core
  import csd_recoder_pkg::*;
#(
  parameter int W = 8,
  localparam int ND = W + 1
) (
  input  logic [W-1:0]  value,
  output logic [ND-1:0] nz,
  output logic [ND-1:0] neg,
  output logic [ND-1:0] dbl
);
  localparam int BW = ((W + 2) / 2) * 2;
  localparam int NG = BW / 2;

  logic [BW:0] padded;
  assign padded = {{(BW - W){1'b0}}, value, 1'b0};

  genvar j;
  generate
    for (j = 0; j < NG; j++) begin : g_grp
      sdigit_t d;
      assign d          = booth_group(padded[2*j+2 -: 3]);
      assign nz[2*j]    = d.nz;
      assign neg[2*j]   = d.neg;
      assign dbl[2*j]   = d.dbl;
      if (2*j + 1 < ND) begin : g_odd
        assign nz[2*j+1]  = 1'b0;
        assign neg[2*j+1] = 1'b0;
        assign dbl[2*j+1] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/csd_popcount.sv
module csd_popcount #(
  parameter int N  = 9,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < N; k++) count = count + CW'(bits[k]);
  end
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
  import csd_recoder_pkg::*;
#(
  parameter int W = 8,
  localparam int ND = W + 1,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_mode,
  input  logic [W-1:0]  in_value,
  output logic          out_valid,
  output logic          out_mode,
  output logic [ND-1:0] out_nz,
  output logic [ND-1:0] out_neg,
  output logic [ND-1:0] out_dbl,
  output logic [CW-1:0] out_count
);
  localparam int SW = W + 3;

  logic [ND-1:0] c_nz, c_neg;
  logic          c_top;
  logic [ND-1:0] b_nz, b_neg, b_dbl;
  logic [ND-1:0] sel_nz, sel_neg, sel_dbl;
  logic [CW-1:0] sel_count;
  rec_mode_e     req_mode;

  csd_core #(.W(W)) u_csd (
    .value(in_value), .nz(c_nz), .neg(c_neg), .top_carry(c_top)
  );

  booth_core #(.W(W)) u_booth (
    .value(in_value), .nz(b_nz), .neg(b_neg), .dbl(b_dbl)
  );

  assign req_mode = rec_mode_e'(in_mode);

  always_comb begin
    if (req_mode == MODE_BOOTH) begin
      sel_nz  = b_nz;
      sel_neg = b_neg;
      sel_dbl = b_dbl;
    end else begin
      sel_nz  = c_nz;
      sel_neg = c_neg;
      sel_dbl = '0;
    end
  end

  csd_popcount #(.N(ND), .CW(CW)) u_pop (.bits(sel_nz), .count(sel_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= 1'b0;
      out_nz    <= '0;
      out_neg   <= '0;
      out_dbl   <= '0;
      out_count <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mode  <= in_mode;
        out_nz    <= sel_nz;
        out_neg   <= sel_neg;
        out_dbl   <= sel_dbl;
        out_count <= sel_count;
      end
    end
  end

  // Value carried by the presented digit string, for the checks below.
  logic signed [SW-1:0] recon_val;
  always_comb begin
    recon_val = '0;
    for (int k = 0; k < ND; k++) begin
      if (out_nz[k]) begin
        if (out_neg[k]) recon_val = recon_val - (SW'(out_dbl[k] ? 2 : 1) <<< k);
        else            recon_val = recon_val + (SW'(out_dbl[k] ? 2 : 1) <<< k);
      end
    end
  end

  logic unused_top;
  assign unused_top = c_top;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> (recon_val == SW'($past(in_value))));

  p_no_adjacent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode |-> ((out_nz & (out_nz >> 1)) == '0));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode |-> (out_count <= CW'((W + 2) / 2)));

  p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_neg & ~out_nz) == '0) && ((out_dbl & ~out_nz) == '0));

  p_no_dbl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode |-> (out_dbl == '0));

  p_booth_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode) |-> (recon_val == SW'($past(in_value))));

  p_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode == $past(in_mode)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_nz) && $stable(out_neg) && $stable(out_count)));
endmodule

// File: tb/csd_recoder_bench.sv
module csd_recoder_bench;
  localparam int W  = 8;
  localparam int ND = W + 1;
  localparam int CW = $clog2(W + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_mode = 1'b0;
  logic [W-1:0]  in_value = '0;
  logic          out_valid, out_mode;
  logic [ND-1:0] out_nz, out_neg, out_dbl;
  logic [CW-1:0] out_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csd_recoder #(.W(W)) u_csd_recoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_value(in_value), .out_valid(out_valid), .out_mode(out_mode),
    .out_nz(out_nz), .out_neg(out_neg), .out_dbl(out_dbl), .out_count(out_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Serial reference: repeatedly strip the low digit, choosing the sign so the rest is even.
  function automatic void ref_csd(input int v, output int nz, output int neg);
    int x = v;
    nz = 0; neg = 0;
    for (int i = 0; i < ND; i++) begin
      if (x % 2 == 1) begin
        nz |= (1 << i);
        if (x % 4 == 3) begin neg |= (1 << i); x = x + 1; end
        else x = x - 1;
      end
      x = x / 2;
    end
  endfunction

  function automatic void ref_booth(input int v, output int nz, output int neg, output int dbl);
    nz = 0; neg = 0; dbl = 0;
    for (int j = 0; 2*j < ND; j++) begin
      int hi = (v >> (2*j+1)) & 1;
      int mid = (v >> (2*j)) & 1;
      int lo = (j == 0) ? 0 : ((v >> (2*j-1)) & 1);
      int d = -2*hi + mid + lo;
      if (d != 0) nz |= (1 << (2*j));
      if (d < 0) neg |= (1 << (2*j));
      if (d == 2 || d == -2) dbl |= (1 << (2*j));
    end
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // Drive a request at a falling edge; its result is checked one cycle later.
  task automatic request(input bit mode, input int v, input string req);
    int enz, eneg, edbl;
    in_valid = 1'b1; in_mode = mode; in_value = W'(v);
    @(negedge clk);
    if (mode) ref_booth(v, enz, eneg, edbl);
    else begin ref_csd(v, enz, eneg); edbl = 0; end
    chk("R1", "out_valid", int'(out_valid), 1);
    chk("R8", "out_mode", int'(out_mode), int'(mode));
    chk(mode ? "R6" : "R2", "out_nz", int'(out_nz), enz);
    chk(mode ? "R6" : "R2", "out_neg", int'(out_neg), eneg);
    chk("R5", "out_dbl", int'(out_dbl), edbl);
    chk("R4", "out_count", int'(out_count), ones(enz));
    if (!mode) chk("R3", "adjacent", int'((out_nz & (out_nz >> 1)) != 0), 0);
  endtask

  task automatic idle(input int v);
    logic [ND-1:0] hnz, hneg;
    logic [CW-1:0] hcnt;
    hnz = out_nz; hneg = out_neg; hcnt = out_count;
    in_valid = 1'b0; in_mode = ~in_mode; in_value = W'(v);
    @(negedge clk);
    chk("R1", "out_valid idle", int'(out_valid), 0);
    chk("R9", "hold nz", int'(out_nz), int'(hnz));
    chk("R9", "hold neg", int'(out_neg), int'(hneg));
    chk("R9", "hold count", int'(out_count), int'(hcnt));
  endtask

  initial begin
    int t = 0;
    while (!done && t < 100000) begin @(posedge clk); t++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd583));
    repeat (2) @(negedge clk);
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset out_nz", int'(out_nz), 0);
    chk("R1", "reset out_count", int'(out_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    request(1'b0, 61, "R7");
    chk("R7", "61 digits nz", int'(out_nz), 9'b001000101);
    chk("R7", "61 digits neg", int'(out_neg), 9'b000000100);

    request(1'b0, 255, "R10");
    chk("R10", "all-ones nz", int'(out_nz), 9'b100000001);
    chk("R10", "all-ones neg", int'(out_neg), 9'b000000001);
    chk("R10", "all-ones count", int'(out_count), 2);

    request(1'b0, 0, "R2");
    request(1'b1, 0, "R6");
    request(1'b1, 255, "R6");
    request(1'b0, 8'hAA, "R2");
    request(1'b1, 8'hAA, "R8");
    request(1'b0, 8'h55, "R8");
    request(1'b1, 8'h55, "R8");
    request(1'b1, 61, "R6");
    idle(8'h33);
    idle(8'hC3);
    request(1'b0, 1, "R2");
    request(1'b0, 8'hAB, "R3");
    idle(0);

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) idle(int'($urandom % 256));
      else request(1'(n), int'($urandom % 256), "R8");
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule